// File: doc/BRIEF.md
# Ping-Pong Peripheral-to-Memory DMA Channel

This block is one DMA channel that copies items from a peripheral into memory, using two control structures in turn. Each structure holds a 32-bit control word plus a source end pointer and a destination end pointer. The control word gives, for each side, the item size and the address step. It also sets the number of items in the buffer, the re-arbitration size and the transfer mode.

The peripheral asks for data with either a single request or a burst request. For each item the channel issues one read beat at the source and one write beat at the destination, on a valid/ready memory bus that carries one beat at a time. When the active structure has moved its last item, the channel does three things at once: it sets that structure's mode field to stopped, raises a completion pulse and switches to the other structure. Software refills the stopped structure through a small register port, so data keeps flowing into the second buffer while the first one is processed.

Registers at `cfg_addr`:
- 0, 1, 2: primary control word, source end, destination end.
- 3, 4, 5: the same three for the alternate structure.
- 6: channel enable. Write bit 0 to set it and bit 1 to clear it.
- 7: burst-only option. Write bit 0 to set it and bit 1 to clear it.

Reading address 6 or 7 returns the status word {sel, burst_only, enable} in bits 2:0. Here `sel` is 0 when the primary structure is active and 1 when the alternate is active.

Top module: `pingpong_dma_channel`

## Requirements
- R1: After reset every register reads 0. `mem_valid`, `busy`, `irq_done` and `irq_err` are 0, and the primary structure is active.
- R2: Control word fields are: destination step in 31:30, destination size in 29:28, source step in 27:26, source size in 25:24, re-arbitration code in 17:14, item count minus one in 13:4, and mode in 2:0. Only mode 3 (ping-pong) moves data.
- R3: The address of an item is the end pointer minus N shifted left by the step code, where N is the current count field. Step code 3 keeps the address fixed at the end pointer. `mem_size` carries the size code (0 byte, 1 halfword, 2 word).
- R4: Each item is one read beat at the source followed by one write beat at the destination. The write carries the read data unchanged and right-aligned. Address, direction and data stay stable while `mem_valid` is high and `mem_ready` is low.
- R5: A burst request moves min(2^code, remaining items) items; any code above 10 counts as 2048. A single request moves exactly one item. Burst wins when both are present.
- R6: While the burst-only option is set, single requests move nothing and leave the count unchanged; burst requests still work.
- R7: After each item other than the last, the active count field is written back decremented by one.
- R8: After the last item, the mode field of the finished structure is set to 0 with its count at 0. `irq_done` pulses for one cycle and the other structure becomes active. If the other structure holds mode 3, transfers continue from it.
- R9: An enabled, idle channel whose active structure holds any mode other than 3 clears its enable and pulses `irq_err` for one cycle, with no bus activity.
- R10: Requests start transfers only while the enable bit is 1. The status word has enable in bit 0, burst-only in bit 1 and sel in bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_single | input | 1 | Single-item request from the peripheral |
| req_burst | input | 1 | Burst request from the peripheral |
| mem_valid | output | 1 | Memory beat valid |
| mem_write | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | AW | Beat address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the current beat |
| mem_rdata | input | DW | Read data, valid when a read beat is accepted |
| busy | output | 1 | A request is being served |
| irq_done | output | 1 | One-cycle pulse when a buffer completes |
| irq_err | output | 1 | One-cycle pulse when the channel stops on a non-ping-pong structure |

## Verification
The bench sweeps three item sizes, five re-arbitration codes (one of them above 10) and three buffer lengths. It checks every read and write address against the buffer base plus the item index. A design that took the address as end plus offset, or that stepped the fixed peripheral address, writes to the wrong place on the first beat.

Burst lengths are compared against the smaller of the window and the items left. A wrong clamp shows up as an overrun on the short last burst. An off-by-one in the count field shows up as one extra or one missing beat per buffer.

The bench then checks the hand-over. A missing mode clear leaves the finished structure runnable, and the expected error interrupt on the later return to it never arrives. A structure rewritten by software during the other buffer must be picked up with no error. Single requests must do nothing while the burst-only option is set, and bursts must do nothing while the channel is disabled.

// File: rtl/pingpong_dma_channel.sv
module pingpong_dma_channel #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          req_single,
  input  logic          req_burst,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          irq_done,
  output logic          irq_err
);

  localparam int CNT_W = 10;
  localparam int LEN_W = CNT_W + 1;
  localparam logic [2:0] MODE_PP = 3'd3;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t           state;
  logic [31:0]      ctl     [2];
  logic [AW-1:0]    src_end [2];
  logic [AW-1:0]    dst_end [2];
  logic             en, burst_only, sel;
  logic [LEN_W-1:0] beats_left;
  logic [DW-1:0]    hold;

  logic [1:0]       dinc, dsz, sinc, ssz;
  logic [3:0]       arb;
  logic [CNT_W-1:0] n_rem;
  logic [2:0]       mode;
  logic [LEN_W:0]   arb_items;
  logic [LEN_W-1:0] rem_items, burst_len;
  logic [AW-1:0]    src_addr, dst_addr;

  function automatic logic [AW-1:0] offset(input logic [CNT_W-1:0] n, input logic [1:0] inc);
    return (inc == 2'd3) ? '0 : (AW'(n) << inc);
  endfunction

  assign dinc  = ctl[sel][31:30];
  assign dsz   = ctl[sel][29:28];
  assign sinc  = ctl[sel][27:26];
  assign ssz   = ctl[sel][25:24];
  assign arb   = ctl[sel][17:14];
  assign n_rem = ctl[sel][13:4];
  assign mode  = ctl[sel][2:0];

  assign arb_items = (arb > 4'd10) ? (LEN_W+1)'(2048) : ((LEN_W+1)'(1) << arb);
  assign rem_items = {1'b0, n_rem} + LEN_W'(1);
  assign burst_len = ({1'b0, rem_items} < arb_items) ? rem_items : arb_items[LEN_W-1:0];

  assign src_addr = src_end[sel] - offset(n_rem, sinc);
  assign dst_addr = dst_end[sel] - offset(n_rem, dinc);

  assign mem_valid = (state != S_IDLE);
  assign mem_write = (state == S_WRITE);
  assign mem_addr  = mem_write ? dst_addr : src_addr;
  assign mem_size  = mem_write ? dsz : ssz;
  assign mem_wdata = hold;
  assign busy      = mem_valid;

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = ctl[0];
      3'd1:    cfg_rdata = 32'(src_end[0]);
      3'd2:    cfg_rdata = 32'(dst_end[0]);
      3'd3:    cfg_rdata = ctl[1];
      3'd4:    cfg_rdata = 32'(src_end[1]);
      3'd5:    cfg_rdata = 32'(dst_end[1]);
      default: cfg_rdata = {29'd0, sel, burst_only, en};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ctl[0]     <= '0;
      ctl[1]     <= '0;
      src_end[0] <= '0;
      src_end[1] <= '0;
      dst_end[0] <= '0;
      dst_end[1] <= '0;
      en         <= 1'b0;
      burst_only <= 1'b0;
      sel        <= 1'b0;
      beats_left <= '0;
      hold       <= '0;
      irq_done   <= 1'b0;
      irq_err    <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: ctl[0]     <= cfg_wdata;
          3'd1: src_end[0] <= cfg_wdata[AW-1:0];
          3'd2: dst_end[0] <= cfg_wdata[AW-1:0];
          3'd3: ctl[1]     <= cfg_wdata;
          3'd4: src_end[1] <= cfg_wdata[AW-1:0];
          3'd5: dst_end[1] <= cfg_wdata[AW-1:0];
          3'd6: begin
            if (cfg_wdata[0]) en <= 1'b1;
            if (cfg_wdata[1]) en <= 1'b0;
          end
          default: begin
            if (cfg_wdata[0]) burst_only <= 1'b1;
            if (cfg_wdata[1]) burst_only <= 1'b0;
          end
        endcase
      end
      case (state)
        S_IDLE: if (en) begin
          if (mode != MODE_PP) begin
            en      <= 1'b0;
            irq_err <= 1'b1;
          end else if (req_burst) begin
            beats_left <= burst_len;
            state      <= S_READ;
          end else if (req_single && !burst_only) begin
            beats_left <= LEN_W'(1);
            state      <= S_READ;
          end
        end
        S_READ: if (mem_ready) begin
          hold  <= mem_rdata;
          state <= S_WRITE;
        end
        default: if (mem_ready) begin
          if (n_rem == '0) begin
            ctl[sel][2:0] <= 3'd0;
            irq_done      <= 1'b1;
            sel           <= ~sel;
            state         <= S_IDLE;
          end else begin
            ctl[sel][13:4] <= n_rem - CNT_W'(1);
            beats_left     <= beats_left - LEN_W'(1);
            state          <= (beats_left == LEN_W'(1)) ? S_IDLE : S_READ;
          end
        end
      endcase
    end
  end

  p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  p_single_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !$past(req_burst) |-> beats_left == LEN_W'(1));

  p_burst_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && burst_only && !req_burst && !cfg_we |=> !busy);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WRITE && mem_ready && n_rem != '0 && !cfg_we |=> n_rem == $past(n_rem) - CNT_W'(1));

  p_done_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> sel != $past(sel) && ctl[~sel][2:0] == 3'd0);

  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> !en && !busy && !irq_done);

endmodule

// File: tb/pingpong_dma_channel_test.sv
module pingpong_dma_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_single = 1'b0, req_burst = 1'b0;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [1:0]  mem_size;
  logic        busy, irq_done, irq_err;

  int total = 0, bad = 0;
  int cyc = 0, seq = 0, idx = 0, wr_cnt = 0, n_done = 0, n_err = 0;
  logic [31:0] last_data = '0;
  logic        exp_sel = 1'b0;
  int          exp_sz = 0;
  logic [31:0] exp_dbase [2];
  logic [31:0] exp_src [2];
  int          exp_items [2];

  pingpong_dma_channel #(.AW(32), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_single(req_single), .req_burst(req_burst),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .irq_done(irq_done), .irq_err(irq_err));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_ready = (cyc % 3) != 2;
    cyc++;
    if (irq_done) n_done++;
    if (irq_err) n_err++;
    if (mem_valid && mem_ready) begin
      if (!mem_write) begin
        chk(mem_addr == exp_src[exp_sel], "R3 source address", mem_addr, exp_src[exp_sel]);
        chk(mem_size == 2'(exp_sz), "R3 source size", mem_size, exp_sz);
        mem_rdata = 32'h5A00_0000 | 32'(seq);
        last_data = mem_rdata;
        seq++;
      end else begin
        chk(mem_addr == exp_dbase[exp_sel] + (32'(idx) << exp_sz), "R3 destination address",
            mem_addr, exp_dbase[exp_sel] + (32'(idx) << exp_sz));
        chk(mem_wdata == last_data, "R4 write data", mem_wdata, last_data);
        idx++;
        wr_cnt++;
        if (idx == exp_items[exp_sel]) begin
          idx = 0;
          exp_sel = ~exp_sel;
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic pulse(input bit b, input bit s, input int exp_n, input string tag);
    int w0, g;
    w0 = wr_cnt;
    @(negedge clk);
    req_burst = b; req_single = s;
    @(negedge clk);
    req_burst = 1'b0; req_single = 1'b0;
    g = 0;
    while (busy && g < 5000) begin @(negedge clk); g++; end
    chk(wr_cnt - w0 == exp_n, tag, wr_cnt - w0, exp_n);
  endtask

  function automatic logic [31:0] cw(input int sz, input int arb, input int n, input int md);
    return {2'(sz), 2'(sz), 2'd3, 2'(sz), 6'd0, 4'(arb), 10'(n - 1), 1'b0, 3'(md)};
  endfunction

  task automatic setup(input int sz, input int arb, input int n0, input int n1, input int md1, input int k);
    exp_sz = sz;
    exp_dbase[0] = 32'h2000_0000 + 32'(k) * 32'h100;
    exp_dbase[1] = 32'h3000_0000 + 32'(k) * 32'h100;
    exp_src[0] = 32'h4000_0010;
    exp_src[1] = 32'h4000_0020;
    exp_items[0] = n0;
    exp_items[1] = n1;
    wr(3'd0, cw(sz, arb, n0, 3));
    wr(3'd1, exp_src[0]);
    wr(3'd2, exp_dbase[0] + (32'(n0 - 1) << sz));
    wr(3'd3, cw(sz, arb, n1, md1));
    wr(3'd4, exp_src[1]);
    wr(3'd5, exp_dbase[1] + (32'(n1 - 1) << sz));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int il[3] = '{1, 4, 7};
    int al[5] = '{0, 1, 2, 3, 12};
    int k, rem, b, nd0, ne0;
    k = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_valid && !busy && !irq_done && !irq_err, "R1 outputs idle",
        {mem_valid, busy, irq_done, irq_err}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 register clear", d, 0);
    end
    rst_n = 1'b1;

    // enabled on a stopped primary: R9 error, no transfer
    nd0 = n_done; ne0 = n_err;
    wr(3'd6, 32'd1);
    repeat (3) @(negedge clk);
    chk(n_err == ne0 + 1, "R9 error on stopped structure", n_err, ne0 + 1);
    rd(3'd6, d);
    chk(d[2:0] == 3'b000, "R9 enable cleared, primary kept", d[2:0], 0);
    pulse(1, 0, 0, "R10 no transfer while disabled");

    for (int si = 0; si < 3; si++)
      for (int ai = 0; ai < 5; ai++)
        for (int ii = 0; ii < 3; ii++) begin
          k++;
          nd0 = n_done; ne0 = n_err;
          setup(si, al[ai], il[ii], il[ii] + 2, 3, k);
          wr(3'd7, 32'd2);
          wr(3'd6, 32'd1);
          rem = il[ii];
          while (rem > 0) begin
            b = ((1 << al[ai]) < rem) ? (1 << al[ai]) : rem;
            pulse(1, 0, b, "R5 burst length");
            rem -= b;
            if (rem > 0) begin
              rd(3'd0, d);
              chk(int'(d[13:4]) == rem - 1, "R7 count write-back", d[13:4], rem - 1);
            end
          end
          repeat (2) @(negedge clk);
          chk(n_done == nd0 + 1, "R8 completion pulse", n_done, nd0 + 1);
          rd(3'd0, d);
          chk(d[2:0] == 0 && d[13:4] == 0, "R8 finished structure stopped", d, 0);
          rd(3'd6, d);
          chk(d[2] == 1'b1, "R8 switched to alternate", d[2], 1);
          rem = il[ii] + 2;
          while (rem > 0) begin
            pulse(0, 1, 1, "R5 single moves one item");
            rem--;
          end
          repeat (3) @(negedge clk);
          chk(n_done == nd0 + 2, "R8 second completion", n_done, nd0 + 2);
          chk(n_err == ne0 + 1, "R9 return to stopped primary", n_err, ne0 + 1);
          rd(3'd6, d);
          chk(d[2:0] == 3'b000, "R9 R10 status after error", d[2:0], 0);
        end

    // non-ping-pong mode in the alternate: R2 and R9
    nd0 = n_done; ne0 = n_err;
    k++;
    setup(1, 1, 2, 3, 1, k);
    wr(3'd6, 32'd1);
    pulse(1, 0, 2, "R2 primary in mode 3 runs");
    repeat (3) @(negedge clk);
    chk(n_err == ne0 + 1, "R2 R9 mode 1 refused", n_err, ne0 + 1);
    pulse(1, 0, 0, "R9 nothing after error");
    // bring selection back to primary with a valid alternate
    exp_items[1] = 1;
    exp_dbase[1] = 32'h3100_0000;
    wr(3'd3, cw(1, 1, 1, 3));
    wr(3'd5, exp_dbase[1]);
    wr(3'd6, 32'd1);
    pulse(1, 0, 1, "R8 alternate after refill");
    repeat (3) @(negedge clk);
    rd(3'd6, d);
    chk(d[2:0] == 3'b000, "R9 back on stopped primary", d[2:0], 0);

    // burst-only option, refill during the other buffer, disable
    nd0 = n_done; ne0 = n_err;
    k++;
    setup(2, 2, 6, 2, 3, k);
    wr(3'd6, 32'd1);
    wr(3'd7, 32'd1);
    rd(3'd6, d);
    chk(d[1:0] == 2'b11, "R10 status bits", d[1:0], 3);
    pulse(0, 1, 0, "R6 single ignored");
    rd(3'd0, d);
    chk(d[13:4] == 10'd5, "R6 count untouched", d[13:4], 5);
    pulse(1, 0, 4, "R6 burst still served");
    wr(3'd7, 32'd2);
    pulse(0, 1, 1, "R6 single after clear");
    pulse(0, 1, 1, "R6 single after clear");
    exp_items[0] = 3;
    exp_dbase[0] = 32'h2800_0000;
    wr(3'd0, cw(2, 2, 3, 3));
    wr(3'd2, exp_dbase[0] + 32'd8);
    pulse(1, 0, 2, "R8 alternate buffer");
    repeat (3) @(negedge clk);
    chk(n_err == ne0, "R8 no error on refilled primary", n_err, ne0);
    rd(3'd6, d);
    chk(d[2] == 1'b0 && d[0] == 1'b1, "R8 running on refilled primary", d[2:0], 1);
    wr(3'd6, 32'd2);
    pulse(1, 0, 0, "R10 request while disabled");
    wr(3'd6, 32'd1);
    pulse(1, 0, 3, "R10 request after re-enable");
    repeat (3) @(negedge clk);
    chk(n_done == nd0 + 3, "R8 completion count", n_done, nd0 + 3);
    chk(n_err == ne0 + 1, "R9 stopped alternate", n_err, ne0 + 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule